// File: doc/BRIEF.md
# Audio Codec Control Register File

This block keeps the small set of 16-bit control words that set the output levels of an audio codec. A link command decoder writes and reads it through a 7-bit register index. Three words are stored: the level of the line output, the level of the mono output and the level of the beep tone. Index 00h is a reset location. A write of any data to it returns every stored word to its power-up value. A read of it returns a fixed capability word.

Each level word carries a mute flag in bit 15 and an attenuation code in its low bits. The block decodes these into a mute signal and a step count that the datapath uses directly. The 6-bit master attenuation code saturates at 31 steps of 1.5 dB each. The 4-bit beep code covers 0 to 15 steps of 3 dB each. A read of a level word returns the stored value exactly as it was written; saturation applies only to the decoded step. Reads are registered and answer one cycle after the request.

Top module: `codec_ctrl_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, all three level words return to 8000h. After that edge, `line_mute`, `mono_mute` and `beep_mute` are 1, every step output is 0, and `rd_valid` is 0.
- R2: A write (`wr_en`=1) to index 00h with any data restores all three level words to 8000h at that edge.
- R3: A read of index 00h returns 0D50h.
- R4: A write to index 02h (line), 06h (mono) or 0Ah (beep) stores all 16 data bits. A later read of that index returns them unchanged, including any code above the saturation point.
- R5: The mute output of each level word equals bit 15 of that word, whatever its attenuation field holds.
- R6: The line and mono step outputs decode bits 5:0 of their word. Codes 00h to 1Fh give the same step value (0 to 31). Any code with bit 5 set gives step 31.
- R7: The beep step output equals bits 3:0 of the word at 0Ah (0 to 15).
- R8: A read of any index other than 00h, 02h, 06h and 0Ah returns 0000h. A write to such an index changes no stored word and no decoded output.
- R9: A read request at a clock edge makes `rd_valid` 1 with `rd_data` valid after that edge. With no request, `rd_valid` is 0 after the edge. A read and a write issued in the same cycle return the contents held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 7 | Write register index |
| wr_data | input | 16 | Write data |
| rd_req | input | 1 | Read request |
| rd_idx | input | 7 | Read register index |
| rd_data | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| line_mute | output | 1 | Line output muted |
| line_step | output | 5 | Line attenuation steps (1.5 dB each) |
| mono_mute | output | 1 | Mono output muted |
| mono_step | output | 5 | Mono attenuation steps (1.5 dB each) |
| beep_mute | output | 1 | Beep muted |
| beep_step | output | 4 | Beep attenuation steps (3 dB each) |

## Verification
The bench drives master codes at both ends of the linear range (00h, 1Fh), a code just past it (25h) and a muted mid-range code. This tells the saturating decode apart from a plain truncation, and it shows that mute is independent of the attenuation field. It writes to odd and high unimplemented indices and then reads back the real words, which separates exact index matching from partial decoding. A write to the reset index with non-zero data, and a read issued in the same cycle as a write, show that the soft reset is keyed on the index alone and that reads return the old contents.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;

    localparam int IDX_W     = 7;
    localparam int DATA_W    = 16;
    localparam int MST_FLD_W = 6;
    localparam int MST_STP_W = 5;
    localparam int BEP_FLD_W = 4;
    localparam int BEP_STP_W = 4;
    localparam int MUTE_POS  = 15;
    localparam int NUM_LVL   = 3;

    localparam logic [IDX_W-1:0] IDX_SOFT_RST = 7'h00;
    localparam logic [IDX_W-1:0] IDX_LINE     = 7'h02;
    localparam logic [IDX_W-1:0] IDX_MONO     = 7'h06;
    localparam logic [IDX_W-1:0] IDX_BEEP     = 7'h0A;

    localparam logic [DATA_W-1:0] CAPS_WORD   = 16'h0D50;
    localparam logic [DATA_W-1:0] LVL_DEFAULT = 16'h8000;

    // slot order of the stored level words
    typedef enum logic [1:0] {
        SLOT_LINE = 2'd0,
        SLOT_MONO = 2'd1,
        SLOT_BEEP = 2'd2
    } lvl_slot_e;

    localparam logic [NUM_LVL-1:0][IDX_W-1:0] LVL_IDX = {IDX_BEEP, IDX_MONO, IDX_LINE};

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rd_resp_t;

    typedef struct packed {
        logic                 mute;
        logic [MST_STP_W-1:0] step;
    } mst_lvl_t;

    typedef struct packed {
        logic                 mute;
        logic [BEP_STP_W-1:0] step;
    } bep_lvl_t;

    function automatic logic is_level_idx(input logic [IDX_W-1:0] idx);
        return (idx == IDX_LINE) || (idx == IDX_MONO) || (idx == IDX_BEEP);
    endfunction

endpackage

// File: rtl/ctrl_word.sv
module ctrl_word #(
    parameter int                 IDX_W   = 7,
    parameter int                 DATA_W  = 16,
    parameter logic [IDX_W-1:0]   ADDR    = '0,
    parameter logic [DATA_W-1:0]  DEFAULT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);

    logic hit;
    assign hit = wr_en && (wr_idx == ADDR);

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            q <= DEFAULT;
        end else if (hit) begin
            q <= wr_data;
        end
    end

    // R4
    wr_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == ADDR && !soft_clr) |=> (q == $past(wr_data)));

endmodule

// File: rtl/level_decode.sv
module level_decode #(
    parameter int FIELD_W = 6,
    parameter int STEP_W  = 5
) (
    input  logic               mute_bit,
    input  logic [FIELD_W-1:0] field,
    output logic               mute,
    output logic [STEP_W-1:0]  step
);

    assign mute = mute_bit;

    generate
        if (FIELD_W > STEP_W) begin : g_sat
            logic over;
            assign over = |field[FIELD_W-1:STEP_W];
            assign step = over ? {STEP_W{1'b1}} : field[STEP_W-1:0];
        end else begin : g_pass
            assign step = field;
        end
    endgenerate

endmodule

// File: rtl/read_port.sv
module read_port
    import codec_reg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_req,
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic [NUM_LVL-1:0][DATA_W-1:0] words,
    output rd_resp_t                       resp
);

    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (rd_idx == IDX_SOFT_RST) begin
            sel = CAPS_WORD;
        end else begin
            for (int i = 0; i < NUM_LVL; i++) begin
                if (rd_idx == LVL_IDX[i]) sel = words[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            resp.vld  <= rd_req;
            resp.data <= rd_req ? sel : '0;
        end
    end

    // R9
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> resp.vld);

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !resp.vld);

endmodule

// File: rtl/codec_ctrl_regfile.sv
module codec_ctrl_regfile
    import codec_reg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_req,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 line_mute,
    output logic [MST_STP_W-1:0] line_step,
    output logic                 mono_mute,
    output logic [MST_STP_W-1:0] mono_step,
    output logic                 beep_mute,
    output logic [BEP_STP_W-1:0] beep_step
);

    logic                           soft_clr;
    logic [NUM_LVL-1:0][DATA_W-1:0] words;
    rd_resp_t                       resp;
    mst_lvl_t                       line_lvl, mono_lvl;
    bep_lvl_t                       beep_lvl;

    assign soft_clr = wr_en && (wr_idx == IDX_SOFT_RST);

    genvar g;
    generate
        for (g = 0; g < NUM_LVL; g++) begin : g_word
            ctrl_word #(
                .IDX_W  (IDX_W),
                .DATA_W (DATA_W),
                .ADDR   (LVL_IDX[g]),
                .DEFAULT(LVL_DEFAULT)
            ) u_word (
                .clk     (clk),
                .rst     (rst),
                .soft_clr(soft_clr),
                .wr_en   (wr_en),
                .wr_idx  (wr_idx),
                .wr_data (wr_data),
                .q       (words[g])
            );
        end
    endgenerate

    level_decode #(.FIELD_W(MST_FLD_W), .STEP_W(MST_STP_W)) u_line_dec (
        .mute_bit(words[SLOT_LINE][MUTE_POS]),
        .field   (words[SLOT_LINE][MST_FLD_W-1:0]),
        .mute    (line_lvl.mute),
        .step    (line_lvl.step)
    );

    level_decode #(.FIELD_W(MST_FLD_W), .STEP_W(MST_STP_W)) u_mono_dec (
        .mute_bit(words[SLOT_MONO][MUTE_POS]),
        .field   (words[SLOT_MONO][MST_FLD_W-1:0]),
        .mute    (mono_lvl.mute),
        .step    (mono_lvl.step)
    );

    level_decode #(.FIELD_W(BEP_FLD_W), .STEP_W(BEP_STP_W)) u_beep_dec (
        .mute_bit(words[SLOT_BEEP][MUTE_POS]),
        .field   (words[SLOT_BEEP][BEP_FLD_W-1:0]),
        .mute    (beep_lvl.mute),
        .step    (beep_lvl.step)
    );

    read_port u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_req(rd_req),
        .rd_idx(rd_idx),
        .words (words),
        .resp  (resp)
    );

    assign rd_data   = resp.data;
    assign rd_valid  = resp.vld;
    assign line_mute = line_lvl.mute;
    assign line_step = line_lvl.step;
    assign mono_mute = mono_lvl.mute;
    assign mono_step = mono_lvl.step;
    assign beep_mute = beep_lvl.mute;
    assign beep_step = beep_lvl.step;

    // R1
    rst_default_chk: assert property (@(posedge clk)
        rst |=> (line_mute && mono_mute && beep_mute &&
                 line_step == '0 && mono_step == '0 && beep_step == '0 && !rd_valid));

    // R2
    soft_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_SOFT_RST) |=>
            (words[SLOT_LINE] == LVL_DEFAULT && words[SLOT_MONO] == LVL_DEFAULT &&
             words[SLOT_BEEP] == LVL_DEFAULT));

    // R3
    caps_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_idx == IDX_SOFT_RST) |=> (rd_data == CAPS_WORD));

    // R5
    line_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_LINE) |=> (line_mute == $past(wr_data[MUTE_POS])));

    // R6
    line_sat_chk: assert property (@(posedge clk) disable iff (rst)
        words[SLOT_LINE][MST_FLD_W-1] |-> (line_step == {MST_STP_W{1'b1}}));

    // R6
    mono_sat_chk: assert property (@(posedge clk) disable iff (rst)
        words[SLOT_MONO][MST_FLD_W-1] |-> (mono_step == {MST_STP_W{1'b1}}));

    // R8
    unimpl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_idx != IDX_SOFT_RST && !is_level_idx(rd_idx)) |=> (rd_data == '0));

    // R8
    unimpl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != IDX_SOFT_RST && !is_level_idx(wr_idx)) |=> $stable(words));

endmodule

// File: tb/test_codec_ctrl_regfile.sv
module test_codec_ctrl_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [6:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        line_mute, mono_mute, beep_mute;
    logic [4:0]  line_step, mono_step;
    logic [3:0]  beep_step;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] m_line = 16'h8000;
    logic [15:0] m_mono = 16'h8000;
    logic [15:0] m_beep = 16'h8000;

    always #2 clk = ~clk;

    codec_ctrl_regfile i_codec_ctrl_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_req(rd_req), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .line_mute(line_mute), .line_step(line_step), .mono_mute(mono_mute),
        .mono_step(mono_step), .beep_mute(beep_mute), .beep_step(beep_step)
    );

    function automatic logic [15:0] model_read(input logic [6:0] idx);
        case (idx)
            7'h00:   return 16'h0D50;
            7'h02:   return m_line;
            7'h06:   return m_mono;
            7'h0A:   return m_beep;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [4:0] mst_step(input logic [15:0] w);
        return w[5] ? 5'd31 : w[4:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [6:0] idx, input logic [15:0] d);
        case (idx)
            7'h00: begin m_line = 16'h8000; m_mono = 16'h8000; m_beep = 16'h8000; end
            7'h02: m_line = d;
            7'h06: m_mono = d;
            7'h0A: m_beep = d;
            default: ;
        endcase
    endtask

    // one bus cycle; entered and left at a falling edge
    task automatic bus(input string tag, input logic do_wr, input logic [6:0] widx,
                       input logic [15:0] wd, input logic do_rd, input logic [6:0] ridx);
        wr_en = do_wr; wr_idx = widx; wr_data = wd;
        rd_req = do_rd; rd_idx = ridx;
        if (do_rd) begin
            exp_q.push_back(model_read(ridx));
            tag_q.push_back(tag);
        end
        if (do_wr) model_write(widx, wd);
        @(negedge clk);
        wr_en = 1'b0; rd_req = 1'b0;
    endtask

    task automatic wr(input string tag, input logic [6:0] idx, input logic [15:0] d);
        bus(tag, 1'b1, idx, d, 1'b0, 7'h00);
    endtask

    task automatic rd(input string tag, input logic [6:0] idx);
        bus(tag, 1'b0, 7'h00, 16'h0, 1'b1, idx);
    endtask

    task automatic check_levels(input string tag);
        check({tag, " line_mute"}, line_mute, m_line[15]);
        check({tag, " line_step"}, line_step, mst_step(m_line));
        check({tag, " mono_mute"}, mono_mute, m_mono[15]);
        check({tag, " mono_step"}, mono_step, mst_step(m_mono));
        check({tag, " beep_mute"}, beep_mute, m_beep[15]);
        check({tag, " beep_step"}, beep_step, m_beep[3:0]);
    endtask

    // monitor: pop expected read data as responses appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: unexpected response actual=%h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_levels("R1");
        check("R1 rd_valid", rd_valid, 1'b0);
        rd("R1 line", 7'h02); rd("R1 mono", 7'h06); rd("R1 beep", 7'h0A);
        // R3
        rd("R3 caps", 7'h00);
        // R9 idle cycle
        @(negedge clk);
        check("R9 idle rd_valid", rd_valid, 1'b0);
        // R5 R6 master decode
        wr("R6", 7'h02, 16'h0000); check_levels("R6 code00");
        wr("R6", 7'h02, 16'h001F); check_levels("R6 code1F");
        wr("R6", 7'h02, 16'h0025); check_levels("R6 code25 sat");
        rd("R4 line raw", 7'h02);
        wr("R5", 7'h06, 16'h8011); check_levels("R5 mono muted");
        wr("R6", 7'h06, 16'h003F); check_levels("R6 code3F sat");
        rd("R4 mono raw", 7'h06);
        // R7 beep
        wr("R7", 7'h0A, 16'h000F); check_levels("R7 beepF");
        wr("R7", 7'h0A, 16'h8007); check_levels("R7 beep muted");
        rd("R4 beep raw", 7'h0A);
        // R8 unimplemented
        wr("R8", 7'h03, 16'hFFFF); check_levels("R8 wr03");
        wr("R8", 7'h42, 16'h0000); check_levels("R8 wr42");
        wr("R8", 7'h0B, 16'h0000); check_levels("R8 wr0B");
        rd("R8 rd03", 7'h03); rd("R8 rd7F", 7'h7F);
        rd("R8 line kept", 7'h02); rd("R8 mono kept", 7'h06); rd("R8 beep kept", 7'h0A);
        // R9 read and write in the same cycle
        bus("R9 same-cycle old data", 1'b1, 7'h02, 16'h1234, 1'b1, 7'h02);
        check_levels("R4 after 1234");
        rd("R4 line 1234", 7'h02);
        // R2 soft reset with non-zero data
        wr("R2", 7'h06, 16'h0005);
        wr("R2", 7'h00, 16'hBEEF);
        check_levels("R2 soft reset");
        rd("R2 line", 7'h02); rd("R2 mono", 7'h06); rd("R2 beep", 7'h0A);
        // R1 reset input after changes
        wr("R1", 7'h02, 16'h0003);
        wr("R1", 7'h0A, 16'h0002);
        rst = 1'b1;
        model_write(7'h00, 16'h0);
        @(negedge clk);
        rst = 1'b0;
        check_levels("R1 reset input");
        check("R1 rd_valid after reset", rd_valid, 1'b0);
        rd("R1 line after reset", 7'h02);
        repeat (2) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule